// File: doc/BRIEF.md
# Video Processor CPU Register Port

This block is the processor-facing side of a tile-based video engine. The CPU reaches it through an 8-bit data path and a 3-bit register offset. The block keeps the settings that the renderer needs: the control byte and the mask byte. It also keeps the scroll state, which is a 15-bit staging address, a 15-bit live video-memory address and a 3-bit horizontal fine scroll. The staging address is built from pairs of byte writes, and one first/second toggle is shared by the scroll port and the address port. The block drives these values straight out to the rendering logic.

Offset 7 is the data window into video memory. The block looks at the live address to pick the region. Palette entries sit in a local 32-entry RAM, and some entries fold onto others. Name-table reads and writes go out on a request port and wait for a reply. Reads of pattern memory pass through a one-deep read-ahead buffer, so the CPU sees the byte from its previous read. The block also holds sprite attribute memory behind an auto-incrementing pointer, a status byte that the renderer can set, and an open-bus latch. Reads of write-only offsets return the value in that latch.

Top module: `vid_reg_port`

## Requirements
- R1: A synchronous reset clears the control, mask, status, fine scroll, staging address, live address, read buffer, open-bus latch and every palette entry. It also sets the toggle to "first" and leaves the CPU and memory ports idle.
- R2: A write to offset 0 stores the control byte and copies bits 1:0 of the byte into staging-address bits 11:10. A write to offset 1 stores the mask byte.
- R3: At offset 5, a first write puts byte bits 2:0 into fine scroll and bits 7:3 into staging bits 4:0. A second write puts bits 2:0 into staging bits 14:12 and bits 7:3 into staging bits 9:5. Every write flips the toggle.
- R4: At offset 6, a first write puts byte bits 5:0 into staging bits 13:8 and clears staging bit 14. A second write puts the byte into staging bits 7:0 and then copies the whole staging address into the live address. Every write flips the toggle.
- R5: A read of offset 2 returns the status byte and then clears status bit 7 and returns the toggle to "first". Each bit set on the status-set input sets that status bit.
- R6: Each accepted access at offset 7, read or write, adds 32 to the 15-bit live address if control bit 2 is 1, and adds 1 if it is 0. The live address wraps at 15 bits.
- R7: An offset-7 read with live-address bits 13:0 below 0x2000 returns the buffered byte. The buffer is then refilled from memory at that address. An offset-7 write below 0x2000 issues no memory request.
- R8: When live-address bits 13:0 are between 0x2000 and 0x3EFF, an offset-7 access raises the memory request for exactly one cycle, carrying that address. The port stays busy until the reply's valid pulse. A read returns the reply byte directly, and a write carries the CPU byte.
- R9: When live-address bits 13:8 equal 0x3F, an offset-7 access uses palette index = address bits 4:0. Bit 4 of the index is cleared when bits 1:0 are zero, for both reads and writes. No memory request is made.
- R10: A write to offset 3 sets the attribute pointer. A write to offset 4 stores the byte at the pointer and then increments the pointer. A read of offset 4 returns the byte at the pointer and leaves the pointer unchanged.
- R11: Writes to offsets 0, 1, 5 and 6 load the open-bus latch. Every read result loads it too. Reads of offsets 0, 1, 3, 5 and 6 return the latch.
- R12: Read data is valid one cycle after an accepted register or palette read, and one cycle after the memory reply for buffered or name-table reads. While the port is busy, CPU accesses are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpuSel | input | 1 | Access strobe, accepted when not busy |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuOfs | input | 3 | Register offset |
| cpuWrData | input | 8 | Write byte |
| cpuRdData | output | 8 | Read byte, valid with cpuRdValid |
| cpuRdValid | output | 1 | One-cycle read-data valid |
| cpuBusy | output | 1 | Memory access outstanding |
| statusSet | input | 8 | Per-bit status set pulses from the renderer |
| memReq | output | 1 | One-cycle memory request |
| memWe | output | 1 | Request is a write |
| memAddr | output | 14 | Request address |
| memWrData | output | 8 | Request write byte |
| memRdData | input | 8 | Reply byte |
| memValid | input | 1 | One-cycle reply strobe, later than the request |
| ctrlReg | output | 8 | Control byte |
| maskReg | output | 8 | Mask byte |
| fineX | output | 3 | Horizontal fine scroll |
| tempAddr | output | 15 | Staging scroll address |
| vramAddr | output | 15 | Live video-memory address |

## Verification
Some rules hold on every cycle, and the bound checker watches them all the time. These are the address step on each data-window access, the control write and its copy into the staging bits, the one-cycle request pulse while busy, read-valid timing, and the fact that nothing moves while a request is outstanding. Other behaviours only show over a series of accesses, so only the bench's scenarios can show them. These are how the shared toggle assembles the staging address, the reset of that toggle by a status read, the palette folding, the one-read lag of the pattern buffer, the open-bus contents and the attribute-pointer stepping.

// File: rtl/vid_reg_pkg.sv
package vid_reg_pkg;

  typedef enum logic [2:0] {
    OFS_CTRL = 3'd0,
    OFS_MASK = 3'd1,
    OFS_STAT = 3'd2,
    OFS_OPTR = 3'd3,
    OFS_ODAT = 3'd4,
    OFS_SCRL = 3'd5,
    OFS_ADDR = 3'd6,
    OFS_DATA = 3'd7
  } regOfs_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } memSt_e;

  // strobes from control to datapath, at most one access group per cycle
  typedef struct packed {
    logic ctrlWr;
    logic maskWr;
    logic oamPtrWr;
    logic oamWr;
    logic scrollWr;
    logic addrWr;
    logic statusRd;
    logic oamRd;
    logic latchRd;
    logic dataStep;
    logic palWr;
    logic palRd;
    logic patDone;
    logic ntDone;
  } strobe_t;

endpackage

// File: rtl/vid_reg_ctrl.sv
module vid_reg_ctrl
  import vid_reg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cpuSel,
  input  logic       cpuWe,
  input  logic [2:0] cpuOfs,
  input  logic [5:0] vramHi,
  input  logic       memValid,
  output strobe_t    stb,
  output logic       memReq,
  output logic       memWe,
  output logic       cpuBusy,
  output logic       cpuRdValid
);

  localparam logic [5:0] PAL_PAGE = 6'h3F;

  memSt_e state;
  logic   opWe;
  logic   opPat;
  logic   accept;
  logic   isPal;
  logic   isPat;
  logic   goMem;
  logic   memDone;

  assign accept  = cpuSel && (state == ST_IDLE);
  assign isPal   = (vramHi == PAL_PAGE);
  assign isPat   = !vramHi[5];
  assign goMem   = accept && (cpuOfs == OFS_DATA) && !isPal && !(cpuWe && isPat);
  assign memDone = (state == ST_WAIT) && memValid;

  always_comb begin
    stb = '0;
    if (accept) begin
      case (regOfs_e'(cpuOfs))
        OFS_CTRL: if (cpuWe) stb.ctrlWr   = 1'b1; else stb.latchRd = 1'b1;
        OFS_MASK: if (cpuWe) stb.maskWr   = 1'b1; else stb.latchRd = 1'b1;
        OFS_STAT: if (!cpuWe) stb.statusRd = 1'b1;
        OFS_OPTR: if (cpuWe) stb.oamPtrWr = 1'b1; else stb.latchRd = 1'b1;
        OFS_ODAT: if (cpuWe) stb.oamWr    = 1'b1; else stb.oamRd   = 1'b1;
        OFS_SCRL: if (cpuWe) stb.scrollWr = 1'b1; else stb.latchRd = 1'b1;
        OFS_ADDR: if (cpuWe) stb.addrWr   = 1'b1; else stb.latchRd = 1'b1;
        default: begin
          stb.dataStep = 1'b1;
          if (isPal) begin
            if (cpuWe) stb.palWr = 1'b1; else stb.palRd = 1'b1;
          end
        end
      endcase
    end
    if (memDone && !opWe) begin
      if (opPat) stb.patDone = 1'b1; else stb.ntDone = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      opWe       <= 1'b0;
      opPat      <= 1'b0;
      cpuRdValid <= 1'b0;
    end else begin
      cpuRdValid <= (accept && !cpuWe && !goMem) || (memDone && !opWe);
      case (state)
        ST_IDLE: if (goMem) begin
          state <= ST_REQ;
          opWe  <= cpuWe;
          opPat <= isPat;
        end
        ST_REQ:  state <= ST_WAIT;
        default: if (memValid) state <= ST_IDLE;
      endcase
    end
  end

  assign memReq  = (state == ST_REQ);
  assign memWe   = (state == ST_REQ) && opWe;
  assign cpuBusy = (state != ST_IDLE);

endmodule

// File: rtl/vid_reg_dp.sv
module vid_reg_dp
  import vid_reg_pkg::*;
#(
  parameter int OAM_DEPTH = 256,
  parameter int PAL_DEPTH = 32,
  parameter int VADDR_W   = 15,
  parameter int MADDR_W   = 14
) (
  input  logic               clk,
  input  logic               rst,
  input  strobe_t            stb,
  input  logic [7:0]         cpuWrData,
  input  logic [7:0]         statusSet,
  input  logic [7:0]         memRdData,
  output logic [7:0]         cpuRdData,
  output logic [7:0]         ctrlReg,
  output logic [7:0]         maskReg,
  output logic [2:0]         fineX,
  output logic [VADDR_W-1:0] tempAddr,
  output logic [VADDR_W-1:0] vramAddr,
  output logic [MADDR_W-1:0] memAddr,
  output logic [7:0]         memWrData
);

  localparam int OAM_AW = $clog2(OAM_DEPTH);
  localparam int PAL_IW = $clog2(PAL_DEPTH);
  localparam logic [VADDR_W-1:0] STEP_ROW = VADDR_W'(32);
  localparam logic [VADDR_W-1:0] STEP_COL = VADDR_W'(1);

  logic [7:0]        statusReg;
  logic [7:0]        statusNext;
  logic [7:0]        openBus;
  logic [7:0]        rdBuf;
  logic              secondWr;
  logic [OAM_AW-1:0] oamAddr;
  logic [7:0]        oamMem [OAM_DEPTH];
  logic [7:0]        palMem [PAL_DEPTH];
  logic [PAL_IW-1:0] palIx;
  logic [7:0]        rdResult;
  logic              rdLoad;

  // folded palette index: entries whose low two bits are zero share the lower bank
  always_comb begin
    palIx = vramAddr[PAL_IW-1:0];
    if (palIx[1:0] == 2'b00) palIx[PAL_IW-1] = 1'b0;
  end

  assign statusNext = (statusReg & ~(stb.statusRd ? 8'h80 : 8'h00)) | statusSet;
  assign rdLoad = stb.statusRd | stb.oamRd | stb.latchRd | stb.palRd | stb.patDone | stb.ntDone;

  always_comb begin
    rdResult = openBus;
    if (stb.statusRd)     rdResult = statusReg;
    else if (stb.oamRd)   rdResult = oamMem[oamAddr];
    else if (stb.palRd)   rdResult = palMem[palIx];
    else if (stb.patDone) rdResult = rdBuf;
    else if (stb.ntDone)  rdResult = memRdData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrlReg   <= '0;
      maskReg   <= '0;
      statusReg <= '0;
      fineX     <= '0;
      tempAddr  <= '0;
      vramAddr  <= '0;
      secondWr  <= 1'b0;
      openBus   <= '0;
      rdBuf     <= '0;
      cpuRdData <= '0;
      oamAddr   <= '0;
      memAddr   <= '0;
      memWrData <= '0;
    end else begin
      statusReg <= statusNext;
      if (stb.ctrlWr) begin
        ctrlReg         <= cpuWrData;
        tempAddr[11:10] <= cpuWrData[1:0];
        openBus         <= cpuWrData;
      end
      if (stb.maskWr) begin
        maskReg <= cpuWrData;
        openBus <= cpuWrData;
      end
      if (stb.scrollWr) begin
        if (!secondWr) begin
          fineX         <= cpuWrData[2:0];
          tempAddr[4:0] <= cpuWrData[7:3];
        end else begin
          tempAddr[14:12] <= cpuWrData[2:0];
          tempAddr[9:5]   <= cpuWrData[7:3];
        end
        secondWr <= !secondWr;
        openBus  <= cpuWrData;
      end
      if (stb.addrWr) begin
        if (!secondWr) begin
          tempAddr[14]   <= 1'b0;
          tempAddr[13:8] <= cpuWrData[5:0];
        end else begin
          tempAddr[7:0] <= cpuWrData;
          vramAddr      <= {tempAddr[14:8], cpuWrData};
        end
        secondWr <= !secondWr;
        openBus  <= cpuWrData;
      end
      if (stb.statusRd) secondWr <= 1'b0;
      if (stb.oamPtrWr) oamAddr <= cpuWrData[OAM_AW-1:0];
      if (stb.oamWr)    oamAddr <= oamAddr + OAM_AW'(1);
      if (stb.dataStep) begin
        vramAddr  <= vramAddr + (ctrlReg[2] ? STEP_ROW : STEP_COL);
        memAddr   <= vramAddr[MADDR_W-1:0];
        memWrData <= cpuWrData;
      end
      if (stb.patDone) rdBuf <= memRdData;
      if (rdLoad) begin
        cpuRdData <= rdResult;
        openBus   <= rdResult;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (stb.oamWr) oamMem[oamAddr] <= cpuWrData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < PAL_DEPTH; i++) palMem[i] <= '0;
    end else if (stb.palWr) begin
      palMem[palIx] <= cpuWrData;
    end
  end

endmodule

// File: rtl/vid_reg_port.sv
module vid_reg_port
  import vid_reg_pkg::*;
#(
  parameter int OAM_DEPTH = 256,
  parameter int PAL_DEPTH = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cpuSel,
  input  logic        cpuWe,
  input  logic [2:0]  cpuOfs,
  input  logic [7:0]  cpuWrData,
  output logic [7:0]  cpuRdData,
  output logic        cpuRdValid,
  output logic        cpuBusy,
  input  logic [7:0]  statusSet,
  output logic        memReq,
  output logic        memWe,
  output logic [13:0] memAddr,
  output logic [7:0]  memWrData,
  input  logic [7:0]  memRdData,
  input  logic        memValid,
  output logic [7:0]  ctrlReg,
  output logic [7:0]  maskReg,
  output logic [2:0]  fineX,
  output logic [14:0] tempAddr,
  output logic [14:0] vramAddr
);

  strobe_t stb;

  vid_reg_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .cpuSel     (cpuSel),
    .cpuWe      (cpuWe),
    .cpuOfs     (cpuOfs),
    .vramHi     (vramAddr[13:8]),
    .memValid   (memValid),
    .stb        (stb),
    .memReq     (memReq),
    .memWe      (memWe),
    .cpuBusy    (cpuBusy),
    .cpuRdValid (cpuRdValid)
  );

  vid_reg_dp #(
    .OAM_DEPTH (OAM_DEPTH),
    .PAL_DEPTH (PAL_DEPTH),
    .VADDR_W   (15),
    .MADDR_W   (14)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .stb       (stb),
    .cpuWrData (cpuWrData),
    .statusSet (statusSet),
    .memRdData (memRdData),
    .cpuRdData (cpuRdData),
    .ctrlReg   (ctrlReg),
    .maskReg   (maskReg),
    .fineX     (fineX),
    .tempAddr  (tempAddr),
    .vramAddr  (vramAddr),
    .memAddr   (memAddr),
    .memWrData (memWrData)
  );

endmodule

// File: rtl/vid_reg_port_chk.sv
module vid_reg_port_chk (
  input logic        clk,
  input logic        rst,
  input logic        cpuSel,
  input logic        cpuWe,
  input logic [2:0]  cpuOfs,
  input logic [7:0]  cpuWrData,
  input logic        cpuBusy,
  input logic        cpuRdValid,
  input logic        memReq,
  input logic        memValid,
  input logic [7:0]  ctrlReg,
  input logic [14:0] tempAddr,
  input logic [14:0] vramAddr
);

  logic taken;
  assign taken = cpuSel && !cpuBusy;

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst) memReq |=> !memReq); // R8
  AST_REQ_BUSY: assert property (@(posedge clk) disable iff (rst) memReq |-> cpuBusy); // R8
  AST_DATA_STEP: assert property (@(posedge clk) disable iff (rst)
    (taken && cpuOfs == 3'd7) |=> vramAddr == $past(vramAddr) + ($past(ctrlReg[2]) ? 15'd32 : 15'd1)); // R6
  AST_CTRL_COPY: assert property (@(posedge clk) disable iff (rst)
    (taken && cpuWe && cpuOfs == 3'd0) |=> (ctrlReg == $past(cpuWrData)) && (tempAddr[11:10] == $past(cpuWrData[1:0]))); // R2
  AST_REG_RD_VALID: assert property (@(posedge clk) disable iff (rst)
    (taken && !cpuWe && cpuOfs != 3'd7) |=> cpuRdValid); // R12
  AST_WR_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    (taken && cpuWe) |=> !cpuRdValid); // R12
  AST_BUSY_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (cpuBusy && !memValid) |=> $stable(vramAddr) && $stable(ctrlReg)); // R12

endmodule

bind vid_reg_port vid_reg_port_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .cpuSel     (cpuSel),
  .cpuWe      (cpuWe),
  .cpuOfs     (cpuOfs),
  .cpuWrData  (cpuWrData),
  .cpuBusy    (cpuBusy),
  .cpuRdValid (cpuRdValid),
  .memReq     (memReq),
  .memValid   (memValid),
  .ctrlReg    (ctrlReg),
  .tempAddr   (tempAddr),
  .vramAddr   (vramAddr)
);

// File: tb/vid_reg_port_bench.sv
`timescale 1ns/1ps
module vid_reg_port_bench;

  typedef struct packed {
    logic        we;
    logic [2:0]  ofs;
    logic [7:0]  data;
    logic [2:0]  kind;   // 0 none, 1 read data, 2 tempAddr, 3 vramAddr, 4 fineX, 5 mask, 6 ctrl
    logic [15:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 49;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 3'd0, 8'h03, 3'd2, 16'h0C00, 4'd2},  // R2 control copies into staging
    '{1'b1, 3'd1, 8'h1E, 3'd5, 16'h001E, 4'd2},  // R2 mask
    '{1'b0, 3'd3, 8'h00, 3'd1, 16'h001E, 4'd11}, // R11 write-only offset returns latch
    '{1'b1, 3'd5, 8'h7D, 3'd4, 16'h0005, 4'd3},  // R3 first scroll write
    '{1'b1, 3'd5, 8'h5E, 3'd2, 16'h6D6F, 4'd3},  // R3 second scroll write
    '{1'b1, 3'd6, 8'h7F, 3'd2, 16'h3F6F, 4'd4},  // R4 first addr write clears bit 14
    '{1'b1, 3'd6, 8'h05, 3'd3, 16'h3F05, 4'd4},  // R4 second addr write copies
    '{1'b1, 3'd7, 8'hAA, 3'd3, 16'h3F06, 4'd6},  // R6 step by one
    '{1'b1, 3'd6, 8'h3F, 3'd0, 16'h0000, 4'd0},
    '{1'b1, 3'd6, 8'h10, 3'd0, 16'h0000, 4'd0},
    '{1'b1, 3'd7, 8'h21, 3'd3, 16'h3F11, 4'd6},  // R6
    '{1'b1, 3'd6, 8'h3F, 3'd0, 16'h0000, 4'd0},
    '{1'b1, 3'd6, 8'h00, 3'd0, 16'h0000, 4'd0},
    '{1'b0, 3'd7, 8'h00, 3'd1, 16'h0021, 4'd9},  // R9 write at index 0x10 folded to 0
    '{1'b1, 3'd6, 8'h3F, 3'd0, 16'h0000, 4'd0},
    '{1'b1, 3'd6, 8'h05, 3'd0, 16'h0000, 4'd0},
    '{1'b0, 3'd7, 8'h00, 3'd1, 16'h00AA, 4'd9},  // R9 plain entry
    '{1'b1, 3'd6, 8'h3F, 3'd0, 16'h0000, 4'd0},
    '{1'b1, 3'd6, 8'h14, 3'd0, 16'h0000, 4'd0},
    '{1'b1, 3'd7, 8'h99, 3'd0, 16'h0000, 4'd0},
    '{1'b1, 3'd6, 8'h3F, 3'd0, 16'h0000, 4'd0},
    '{1'b1, 3'd6, 8'h04, 3'd0, 16'h0000, 4'd0},
    '{1'b0, 3'd7, 8'h00, 3'd1, 16'h0099, 4'd9},  // R9 index 0x14 lands on 0x04
    '{1'b0, 3'd1, 8'h00, 3'd1, 16'h0099, 4'd11}, // R11 read result loaded latch
    '{1'b1, 3'd5, 8'h66, 3'd4, 16'h0006, 4'd3},  // R3
    '{1'b0, 3'd0, 8'h00, 3'd1, 16'h0066, 4'd11}, // R11 scroll write loaded latch
    '{1'b1, 3'd5, 8'h00, 3'd0, 16'h0000, 4'd0},
    '{1'b1, 3'd3, 8'h10, 3'd0, 16'h0000, 4'd0},
    '{1'b1, 3'd4, 8'h44, 3'd0, 16'h0000, 4'd0},
    '{1'b1, 3'd4, 8'h55, 3'd0, 16'h0000, 4'd0},
    '{1'b0, 3'd1, 8'h00, 3'd1, 16'h0000, 4'd11}, // R11 offset 4 writes leave latch
    '{1'b1, 3'd3, 8'h10, 3'd0, 16'h0000, 4'd0},
    '{1'b0, 3'd4, 8'h00, 3'd1, 16'h0044, 4'd10}, // R10
    '{1'b0, 3'd4, 8'h00, 3'd1, 16'h0044, 4'd10}, // R10 read does not advance
    '{1'b1, 3'd3, 8'h11, 3'd0, 16'h0000, 4'd0},
    '{1'b0, 3'd4, 8'h00, 3'd1, 16'h0055, 4'd10}, // R10 write advanced pointer
    '{1'b1, 3'd6, 8'h21, 3'd0, 16'h0000, 4'd0},
    '{1'b0, 3'd2, 8'h00, 3'd1, 16'h0000, 4'd5},  // R5 status read
    '{1'b1, 3'd6, 8'h22, 3'd0, 16'h0000, 4'd0},
    '{1'b1, 3'd6, 8'h00, 3'd3, 16'h2200, 4'd5},  // R5 toggle was reset
    '{1'b0, 3'd7, 8'h00, 3'd1, 16'h0011, 4'd8},  // R8 name-table read direct
    '{1'b1, 3'd0, 8'h04, 3'd6, 16'h0004, 4'd2},  // R2
    '{1'b0, 3'd7, 8'h00, 3'd1, 16'h0012, 4'd8},  // R8
    '{1'b0, 3'd3, 8'h00, 3'd3, 16'h2221, 4'd6},  // R6 step by 32
    '{1'b1, 3'd6, 8'h01, 3'd0, 16'h0000, 4'd0},
    '{1'b1, 3'd6, 8'h23, 3'd0, 16'h0000, 4'd0},
    '{1'b0, 3'd7, 8'h00, 3'd1, 16'h0000, 4'd7},  // R7 stale buffer first
    '{1'b0, 3'd7, 8'h00, 3'd1, 16'h0034, 4'd7},  // R7 previous fetch
    '{1'b0, 3'd3, 8'h00, 3'd3, 16'h0163, 4'd6}   // R6
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        cpuSel, cpuWe;
  logic [2:0]  cpuOfs;
  logic [7:0]  cpuWrData, cpuRdData, statusSet, memWrData, memRdData;
  logic        cpuRdValid, cpuBusy, memReq, memWe, memValid;
  logic [13:0] memAddr;
  logic [7:0]  ctrlReg, maskReg;
  logic [2:0]  fineX;
  logic [14:0] tempAddr, vramAddr;

  int nChecks = 0;
  int nFails  = 0;
  logic        pend;
  int          reqCount;
  logic [13:0] lastWrAddr;
  logic [7:0]  lastWrData;

  always #2 clk = ~clk;

  vid_reg_port u_vid_reg_port (
    .clk(clk), .rst(rst), .cpuSel(cpuSel), .cpuWe(cpuWe), .cpuOfs(cpuOfs),
    .cpuWrData(cpuWrData), .cpuRdData(cpuRdData), .cpuRdValid(cpuRdValid),
    .cpuBusy(cpuBusy), .statusSet(statusSet), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWrData(memWrData), .memRdData(memRdData),
    .memValid(memValid), .ctrlReg(ctrlReg), .maskReg(maskReg), .fineX(fineX),
    .tempAddr(tempAddr), .vramAddr(vramAddr)
  );

  // memory model: reply two edges after the request, data = low address byte + 0x11
  always @(posedge clk) begin
    if (rst) begin
      pend     <= 1'b0;
      memValid <= 1'b0;
    end else begin
      memValid <= 1'b0;
      if (memReq) begin
        pend     <= 1'b1;
        reqCount <= reqCount + 1;
        if (memWe) begin
          lastWrAddr <= memAddr;
          lastWrData <= memWrData;
        end
      end
      if (pend) begin
        pend      <= 1'b0;
        memValid  <= 1'b1;
        memRdData <= memAddr[7:0] + 8'h11;
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic acc(input logic we, input logic [2:0] ofs, input logic [7:0] d,
                     output logic [7:0] rd, output int lat);
    @(negedge clk);
    cpuSel = 1'b1; cpuWe = we; cpuOfs = ofs; cpuWrData = d;
    @(negedge clk);
    cpuSel = 1'b0; cpuWe = 1'b0;
    lat = 1;
    while (!(we ? !cpuBusy : cpuRdValid) && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    rd = cpuRdData;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL R12 watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int lat;
    int reqBefore;
    rst = 1'b1; cpuSel = 1'b0; cpuWe = 1'b0; cpuOfs = '0; cpuWrData = '0;
    statusSet = '0; reqCount = 0; lastWrAddr = '0; lastWrData = '0; memRdData = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1", "ctrl", {8'h0, ctrlReg}, 16'h0);
    chk("R1", "mask", {8'h0, maskReg}, 16'h0);
    chk("R1", "fineX", {13'h0, fineX}, 16'h0);
    chk("R1", "temp", {1'b0, tempAddr}, 16'h0);
    chk("R1", "vram", {1'b0, vramAddr}, 16'h0);
    chk("R1", "idle", {13'h0, cpuBusy, memReq, cpuRdValid}, 16'h0);

    for (int i = 0; i < NVEC; i++) begin
      acc(VEC[i].we, VEC[i].ofs, VEC[i].data, rd, lat);
      case (VEC[i].kind)
        3'd1: chk($sformatf("R%0d", VEC[i].req), $sformatf("vec %0d read", i), {8'h0, rd}, VEC[i].exp);
        3'd2: chk($sformatf("R%0d", VEC[i].req), $sformatf("vec %0d temp", i), {1'b0, tempAddr}, VEC[i].exp);
        3'd3: chk($sformatf("R%0d", VEC[i].req), $sformatf("vec %0d vram", i), {1'b0, vramAddr}, VEC[i].exp);
        3'd4: chk($sformatf("R%0d", VEC[i].req), $sformatf("vec %0d fineX", i), {13'h0, fineX}, VEC[i].exp);
        3'd5: chk($sformatf("R%0d", VEC[i].req), $sformatf("vec %0d mask", i), {8'h0, maskReg}, VEC[i].exp);
        3'd6: chk($sformatf("R%0d", VEC[i].req), $sformatf("vec %0d ctrl", i), {8'h0, ctrlReg}, VEC[i].exp);
        default: ;
      endcase
    end

    // R5 status set pulses, read clears only bit 7
    @(negedge clk); statusSet = 8'hC0;
    @(negedge clk); statusSet = 8'h00;
    acc(1'b0, 3'd2, 8'h00, rd, lat);
    chk("R5", "status first", {8'h0, rd}, 16'h00C0);
    acc(1'b0, 3'd2, 8'h00, rd, lat);
    chk("R5", "status second", {8'h0, rd}, 16'h0040);

    // R8 name-table write goes out with address and byte
    acc(1'b1, 3'd6, 8'h20, rd, lat);
    acc(1'b1, 3'd6, 8'h00, rd, lat);
    acc(1'b1, 3'd0, 8'h00, rd, lat);
    reqBefore = reqCount;
    acc(1'b1, 3'd7, 8'h5C, rd, lat);
    chk("R8", "nt write count", 16'(reqCount - reqBefore), 16'd1);
    chk("R8", "nt write addr", {2'b0, lastWrAddr}, 16'h2000);
    chk("R8", "nt write data", {8'h0, lastWrData}, 16'h005C);
    chk("R6", "vram after nt write", {1'b0, vramAddr}, 16'h2001);

    // R7 pattern write issues no request
    acc(1'b1, 3'd6, 8'h00, rd, lat);
    acc(1'b1, 3'd6, 8'h40, rd, lat);
    reqBefore = reqCount;
    acc(1'b1, 3'd7, 8'h12, rd, lat);
    repeat (3) @(negedge clk);
    chk("R7", "pattern write requests", 16'(reqCount - reqBefore), 16'd0);
    chk("R7", "vram after pattern write", {1'b0, vramAddr}, 16'h0041);

    // R12 access ignored while busy, read latency through memory
    acc(1'b1, 3'd6, 8'h21, rd, lat);
    acc(1'b1, 3'd6, 8'h00, rd, lat);
    @(negedge clk);
    cpuSel = 1'b1; cpuWe = 1'b0; cpuOfs = 3'd7;
    @(negedge clk);
    cpuWe = 1'b1; cpuOfs = 3'd0; cpuWrData = 8'hFF;
    lat = 1;
    @(negedge clk);
    cpuSel = 1'b0; cpuWe = 1'b0;
    lat = 2;
    while (!cpuRdValid && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    chk("R12", "mem read latency", 16'(lat), 16'd4);
    chk("R12", "mem read data", {8'h0, cpuRdData}, 16'h0011);
    chk("R12", "ctrl untouched while busy", {8'h0, ctrlReg}, 16'h0000);

    // R1 reset clears palette and registers
    acc(1'b1, 3'd0, 8'h80, rd, lat);
    doReset();
    chk("R1", "ctrl after reset", {8'h0, ctrlReg}, 16'h0);
    chk("R1", "vram after reset", {1'b0, vramAddr}, 16'h0);
    acc(1'b1, 3'd6, 8'h3F, rd, lat);
    acc(1'b1, 3'd6, 8'h05, rd, lat);
    acc(1'b0, 3'd7, 8'h00, rd, lat);
    chk("R1", "palette after reset", {8'h0, rd}, 16'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule